// File: doc/BRIEF.md
# Operand Bypass and Load-Use Stall Control

This block is the steering logic for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each cycle it looks at the source registers of the instruction entering the ALU and at the destinations of the two older instructions still in flight. For each ALU operand it produces a select code that tells the operand multiplexer to take the value from the register file, from the execute/memory pipeline register, or from the memory/writeback pipeline register. When both older instructions write the same register, the newer one wins. A chain of up to three consumers after a producer therefore gets the right value.

One case cannot be covered by bypassing: a load that is followed at once by an instruction reading the loaded register. In that case the block raises a hold, which freezes the program counter and the fetch/decode register, and a bubble request, which turns the execute-stage entry into a no-operation for one cycle. Register reads happen only in decode and writes only in writeback, so write-after-read and write-after-write conflicts cannot occur and are not checked. The block also contains the decode-stage read bypass. When writeback writes a register that decode reads in the same cycle, the new value is passed through.

All outputs are combinational functions of the inputs. The clock and active-low reset are used only by the embedded property checks.

Top module: `hazard_ctl`

## Requirements
- R1: When the execute/memory stage writes (mem_wen=1) a nonzero register equal to an execute-stage source, that operand's select is 2'b10.
- R2: When only the memory/writeback stage writes (wb_wen=1) a nonzero register equal to an execute-stage source, that operand's select is 2'b01.
- R3: With no qualifying match the select is 2'b00 (register file), and the code 2'b11 never appears.
- R4: When both older stages match the same source, the execute/memory stage (2'b10) takes priority.
- R5: A source of register 0, or a producer whose write enable is low, never causes bypassing.
- R6: When the execute stage holds a load (ex_is_load=1) whose nonzero destination equals either decode source, hold_fetch and insert_bubble are both 1.
- R7: No stall is raised for a non-load in execute, for a load into register 0, or for a load whose destination matches neither decode source.
- R8: When writeback writes a nonzero register that decode reads, the decode operand output equals wb_data; otherwise it equals the register-file read data.
- R9: The A and B operands are decided independently; a match on one does not affect the other's select or read value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded checks only |
| rst_n | input | 1 | Active-low reset that disables the checks |
| id_src_a | input | AW | Decode-stage source A register |
| id_src_b | input | AW | Decode-stage source B register |
| ex_src_a | input | AW | Execute-stage source A register |
| ex_src_b | input | AW | Execute-stage source B register |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| ex_dst | input | AW | Execute-stage destination register |
| mem_dst | input | AW | Execute/memory register destination |
| mem_wen | input | 1 | Execute/memory register write enable |
| wb_dst | input | AW | Memory/writeback register destination |
| wb_wen | input | 1 | Memory/writeback register write enable |
| wb_data | input | XLEN | Value being written back |
| id_rf_a | input | XLEN | Register-file read data for source A |
| id_rf_b | input | XLEN | Register-file read data for source B |
| fwd_a | output | 2 | ALU operand A select (00 file, 10 exec/mem, 01 mem/wb) |
| fwd_b | output | 2 | ALU operand B select |
| hold_fetch | output | 1 | Freeze program counter and fetch/decode register |
| insert_bubble | output | 1 | Replace execute-stage entry with a no-operation |
| id_opnd_a | output | XLEN | Decode operand A after writeback bypass |
| id_opnd_b | output | XLEN | Decode operand B after writeback bypass |

## Verification
On every clock the embedded properties check that the select code is never 2'b11. They also check that register 0 is never bypassed, that the newer stage wins a double match, that a stall never appears without a load in execute, that hold and bubble agree, and that the decode bypass returns the written value. The bench's sweeps alone show the complete mapping. They cover every combination of sources, destinations and enables in a four-register configuration, so that each select code, the absence of a stall, and the independence of the two operands are checked against values the bench computes itself.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_WB  = 2'b01,
    SRC_MEM = 2'b10
  } opnd_src_e;

  localparam int NUM_OPND = 2;
endpackage

// File: rtl/fwd_select.sv
module fwd_select
  import hazard_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] mem_dst,
  input  logic          mem_wen,
  input  logic [AW-1:0] wb_dst,
  input  logic          wb_wen,
  output opnd_src_e     sel
);
  logic src_live;
  logic hit_mem;
  logic hit_wb;

  assign src_live = (src != '0);
  assign hit_mem  = src_live && mem_wen && (mem_dst == src);
  assign hit_wb   = src_live && wb_wen  && (wb_dst  == src);

  always_comb begin
    if (hit_mem)     sel = SRC_MEM;
    else if (hit_wb) sel = SRC_WB;
    else             sel = SRC_RF;
  end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
  parameter int AW = 5
) (
  input  logic          ex_is_load,
  input  logic [AW-1:0] ex_dst,
  input  logic [AW-1:0] id_src_a,
  input  logic [AW-1:0] id_src_b,
  output logic          stall
);
  logic dst_live;
  logic uses_dst;

  assign dst_live = ex_is_load && (ex_dst != '0);
  assign uses_dst = (ex_dst == id_src_a) || (ex_dst == id_src_b);
  assign stall    = dst_live && uses_dst;
endmodule

// File: rtl/id_read_bypass.sv
module id_read_bypass #(
  parameter int AW   = 5,
  parameter int XLEN = 32
) (
  input  logic [AW-1:0]   src,
  input  logic [XLEN-1:0] rf_data,
  input  logic [AW-1:0]   wb_dst,
  input  logic            wb_wen,
  input  logic [XLEN-1:0] wb_data,
  output logic [XLEN-1:0] opnd
);
  logic take_wb;

  assign take_wb = wb_wen && (wb_dst != '0) && (wb_dst == src);
  assign opnd    = take_wb ? wb_data : rf_data;
endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
  import hazard_pkg::*;
#(
  parameter int AW   = 5,
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   id_src_a,
  input  logic [AW-1:0]   id_src_b,
  input  logic [AW-1:0]   ex_src_a,
  input  logic [AW-1:0]   ex_src_b,
  input  logic            ex_is_load,
  input  logic [AW-1:0]   ex_dst,
  input  logic [AW-1:0]   mem_dst,
  input  logic            mem_wen,
  input  logic [AW-1:0]   wb_dst,
  input  logic            wb_wen,
  input  logic [XLEN-1:0] wb_data,
  input  logic [XLEN-1:0] id_rf_a,
  input  logic [XLEN-1:0] id_rf_b,
  output logic [1:0]      fwd_a,
  output logic [1:0]      fwd_b,
  output logic            hold_fetch,
  output logic            insert_bubble,
  output logic [XLEN-1:0] id_opnd_a,
  output logic [XLEN-1:0] id_opnd_b
);
  logic [NUM_OPND-1:0][AW-1:0]   ex_src;
  logic [NUM_OPND-1:0][AW-1:0]   id_src;
  logic [NUM_OPND-1:0][XLEN-1:0] rf_rd;
  logic [NUM_OPND-1:0][XLEN-1:0] id_out;
  opnd_src_e                     sel [NUM_OPND];
  logic                          stall;

  assign ex_src = {ex_src_b, ex_src_a};
  assign id_src = {id_src_b, id_src_a};
  assign rf_rd  = {id_rf_b, id_rf_a};

  for (genvar gi = 0; gi < NUM_OPND; gi++) begin : g_opnd
    fwd_select #(.AW(AW)) u_sel (
      .src     (ex_src[gi]),
      .mem_dst (mem_dst),
      .mem_wen (mem_wen),
      .wb_dst  (wb_dst),
      .wb_wen  (wb_wen),
      .sel     (sel[gi])
    );

    id_read_bypass #(.AW(AW), .XLEN(XLEN)) u_byp (
      .src     (id_src[gi]),
      .rf_data (rf_rd[gi]),
      .wb_dst  (wb_dst),
      .wb_wen  (wb_wen),
      .wb_data (wb_data),
      .opnd    (id_out[gi])
    );
  end

  load_use_detect #(.AW(AW)) u_lu (
    .ex_is_load (ex_is_load),
    .ex_dst     (ex_dst),
    .id_src_a   (id_src_a),
    .id_src_b   (id_src_b),
    .stall      (stall)
  );

  assign fwd_a         = sel[0];
  assign fwd_b         = sel[1];
  assign hold_fetch    = stall;
  assign insert_bubble = stall;
  assign id_opnd_a     = id_out[0];
  assign id_opnd_b     = id_out[1];

  // Select code 2'b11 is never produced (R3)
  assert_legal_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a != 2'b11) && (fwd_b != 2'b11));

  // Newer stage wins a double match on operand A (R4)
  assert_mem_priority_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wen && wb_wen && ex_src_a != '0 && mem_dst == ex_src_a && wb_dst == ex_src_a)
      |-> (fwd_a == 2'b10));

  // Register 0 is never bypassed (R5)
  assert_zero_reg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_src_b == '0) |-> (fwd_b == 2'b00));

  // A stall requires a load in execute and asserts both controls (R6, R7)
  assert_stall_needs_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_fetch |-> (ex_is_load && insert_bubble && ex_dst != '0));

  // Decode read returns the value being written back (R8)
  assert_id_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_wen && wb_dst != '0 && wb_dst == id_src_b) |-> (id_opnd_b == wb_data));
endmodule

// File: tb/hazard_ctl_test.sv
module hazard_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 2;
  localparam int XLEN = 8;
  localparam int NREG = 1 << AW;

  logic            clk = 0;
  logic            rst_n = 0;
  logic [AW-1:0]   id_src_a = 0, id_src_b = 0, ex_src_a = 0, ex_src_b = 0;
  logic            ex_is_load = 0;
  logic [AW-1:0]   ex_dst = 0, mem_dst = 0, wb_dst = 0;
  logic            mem_wen = 0, wb_wen = 0;
  logic [XLEN-1:0] wb_data = 0, id_rf_a = 0, id_rf_b = 0;
  logic [1:0]      fwd_a, fwd_b;
  logic            hold_fetch, insert_bubble;
  logic [XLEN-1:0] id_opnd_a, id_opnd_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hazard_ctl #(.AW(AW), .XLEN(XLEN)) uut (
    .clk(clk), .rst_n(rst_n),
    .id_src_a(id_src_a), .id_src_b(id_src_b),
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
    .ex_is_load(ex_is_load), .ex_dst(ex_dst),
    .mem_dst(mem_dst), .mem_wen(mem_wen),
    .wb_dst(wb_dst), .wb_wen(wb_wen), .wb_data(wb_data),
    .id_rf_a(id_rf_a), .id_rf_b(id_rf_b),
    .fwd_a(fwd_a), .fwd_b(fwd_b),
    .hold_fetch(hold_fetch), .insert_bubble(insert_bubble),
    .id_opnd_a(id_opnd_a), .id_opnd_b(id_opnd_b)
  );

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_sel(logic [AW-1:0] s, logic [AW-1:0] md, logic mw,
                                         logic [AW-1:0] wd, logic ww);
    if (s != 0 && mw && md == s) return 2'b10;
    if (s != 0 && ww && wd == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string sel_tag(logic [AW-1:0] s, logic [AW-1:0] md, logic mw,
                                    logic [AW-1:0] wd, logic ww);
    if (s == 0) return "R5";
    if (mw && md == s && ww && wd == s) return "R4";
    if (mw && md == s) return "R1";
    if (ww && wd == s) return "R2";
    return "R3";
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // Reset state: all-zero inputs give register-file selects and no stall (R3, R7)
    repeat (2) @(negedge clk);
    chk("R3 reset fwd_a", fwd_a, 0);
    chk("R3 reset fwd_b", fwd_b, 0);
    chk("R7 reset hold", hold_fetch, 0);
    chk("R7 reset bubble", insert_bubble, 0);
    rst_n = 1;

    // Sweep 1: every forwarding combination (R1..R5, R9)
    for (int sa = 0; sa < NREG; sa++)
      for (int sb = 0; sb < NREG; sb++)
        for (int md = 0; md < NREG; md++)
          for (int mw = 0; mw < 2; mw++)
            for (int wd = 0; wd < NREG; wd++)
              for (int ww = 0; ww < 2; ww++) begin
                @(negedge clk);
                ex_src_a = AW'(sa); ex_src_b = AW'(sb);
                mem_dst = AW'(md); mem_wen = 1'(mw);
                wb_dst = AW'(wd); wb_wen = 1'(ww);
                #1;
                chk({sel_tag(ex_src_a, mem_dst, mem_wen, wb_dst, wb_wen), " R9 fwd_a"},
                    fwd_a, exp_sel(ex_src_a, mem_dst, mem_wen, wb_dst, wb_wen));
                chk({sel_tag(ex_src_b, mem_dst, mem_wen, wb_dst, wb_wen), " R9 fwd_b"},
                    fwd_b, exp_sel(ex_src_b, mem_dst, mem_wen, wb_dst, wb_wen));
              end

    // Sweep 2: load-use stall and decode read bypass (R6, R7, R8, R9)
    ex_src_a = 0; ex_src_b = 0; mem_wen = 0;
    for (int ia = 0; ia < NREG; ia++)
      for (int ib = 0; ib < NREG; ib++)
        for (int ld = 0; ld < 2; ld++)
          for (int ed = 0; ed < NREG; ed++)
            for (int ww = 0; ww < 2; ww++)
              for (int wd = 0; wd < NREG; wd++) begin
                logic st;
                logic [XLEN-1:0] ea, eb;
                @(negedge clk);
                id_src_a = AW'(ia); id_src_b = AW'(ib);
                ex_is_load = 1'(ld); ex_dst = AW'(ed);
                wb_wen = 1'(ww); wb_dst = AW'(wd);
                id_rf_a = XLEN'(8'h10 + ia); id_rf_b = XLEN'(8'h20 + ib);
                wb_data = XLEN'(8'hA0 + ed * 4 + wd);
                #1;
                st = (ld == 1) && (ed != 0) && (ed == ia || ed == ib);
                ea = (ww == 1 && wd != 0 && wd == ia) ? wb_data : id_rf_a;
                eb = (ww == 1 && wd != 0 && wd == ib) ? wb_data : id_rf_b;
                chk(st ? "R6 hold" : "R7 hold", hold_fetch, st);
                chk(st ? "R6 bubble" : "R7 bubble", insert_bubble, st);
                chk("R8 R9 id_opnd_a", id_opnd_a, ea);
                chk("R8 R9 id_opnd_b", id_opnd_b, eb);
              end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule